// File: doc/BRIEF.md
# Reset-Time Mode Strap Sampler

This block reads configuration strap pins around the moment a chip leaves reset and then holds the operating modes they select until the next reset. Two active-low test straps choose between normal operation and a test mode in which every chip output goes to high impedance. Two active-low clock-select straps choose the multiplier code for the clock generator. While reset is held, the block also enables weak pullups on the strap pins, so an unconnected strap reads high.

All strap inputs pass through a multi-stage synchronizer in the crystal clock domain. The reset input is assumed synchronous to that clock. The first clock edge that sees the reset input high after it was low is the release edge. The test straps are captured at the release edge. The clock-select straps are captured a fixed, small number of edges later, inside a capture window. After capture, nothing on the strap pins can change either result until reset is asserted again.

Top module: `strap_mode_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `test_hiz` is 0 and `clk_mode` is the multiply-by-four code 2'b10 after that edge.
- R2: `strap_pull_en` is 1 whenever `rst_n` is low and 0 whenever `rst_n` is high.
- R3: At the release edge, `test_hiz` becomes 1 if both bits of `test_strap_n` were sampled low, and 0 for any other value.
- R4: Once set, `test_hiz` keeps its value on every clock edge until `rst_n` is asserted again.
- R5: The clock-select straps are decoded as follows. If `ck_strap_n[1]` is low, the code is multiply-by-one, 2'b00. If only `ck_strap_n[0]` is low, the code is multiply-by-two, 2'b01. If neither is low, the code is multiply-by-four, 2'b10.
- R6: `clk_mode` takes the decoded value on the third clock edge counting the release edge as the first, which is within three crystal clocks of release. Before that edge it keeps the multiply-by-four default. The decoded value comes from the clock-select level present at the release edge.
- R7: Strap changes made after the release edge have no effect on `test_hiz` or `clk_mode`.
- R8: Because of the two-stage synchronizer, the test strap value captured at the release edge is the one present at the clock edge two edges before release. A change made after that edge is not seen.
- R9: `clk_mode` never shows the unused code 2'b11, and it does not change between capture and the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-domain clock |
| rst_n | input | 1 | Reset input, active low, synchronous to `clk` |
| test_strap_n | input | 2 | Active-low test-mode straps |
| ck_strap_n | input | 2 | Active-low clock-select straps |
| test_hiz | output | 1 | Test mode latched; all chip outputs go to high impedance |
| clk_mode | output | 2 | Latched clock multiplier code |
| strap_pull_en | output | 1 | Enables the weak pullups on the strap pins during reset |

## Verification
The bench builds the block with its default values: a two-stage synchronizer and a three-clock capture window. With these values the release edge, the third-edge capture and the two-edge synchronizer lag all fall on exact, predictable cycles. The bench drives every one of the sixteen strap combinations through a full reset cycle. After each release it inverts and toggles the straps to confirm the latched results hold. One further sequence changes the straps in the narrow gap between the synchronizer's last sample before release and the release edge itself. This shows that the test straps and the clock-select straps are taken from different moments.

// File: rtl/msl_pkg.sv
// Package msl_pkg
// Purpose : clock multiplier codes and the strap decode shared by the sampler.
// Assumes : clock-select straps are active low; a low on bit 1 wins over bit 0.
package msl_pkg;

    typedef enum logic [1:0] {
        CKM_X1 = 2'b00,
        CKM_X2 = 2'b01,
        CKM_X4 = 2'b10
    } ckmode_e;

    // Map the active-low clock-select straps to a multiplier code.
    function automatic ckmode_e decode_ck(input logic [1:0] sel_n);
        ckmode_e m;
        if (!sel_n[1])      m = CKM_X1;
        else if (!sel_n[0]) m = CKM_X2;
        else                m = CKM_X4;
        return m;
    endfunction

endpackage

// File: rtl/msl_sync.sv
// Module msl_sync
// Purpose : multi-stage synchronizer for a bundle of strap inputs.
// Assumes : STAGES >= 1. The stages are not reset, because they must keep
//           sampling the pins while reset is held.
module msl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // First stage samples the pins directly.
    always_ff @(posedge clk) begin
        stage[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-samples the stage before it.
            always_ff @(posedge clk) begin
                stage[gi] <= stage[gi-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/msl_window.sv
// Module msl_window
// Purpose : finds the reset release edge and times the capture of the
//           clock-select straps inside a window of clocks after release.
// Assumes : rst_n is synchronous to clk; WINDOW >= 1.
module msl_window #(
    parameter int WINDOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic release_o,
    output logic capture_o
);

    localparam int LAST = WINDOW - 1;
    localparam int CW   = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic          rst_q;
    logic [CW-1:0] cnt;
    logic          done;

    // Hold last cycle's reset level so the release edge can be seen.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    assign release_o = rst_n & ~rst_q;

    // Count edges from release; stop once the capture edge has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(LAST)) done <= 1'b1;
            else                  cnt  <= cnt + 1'b1;
        end
    end

    assign capture_o = rst_n & ~done & (cnt == CW'(LAST));

    // R6: a capture closes the window on the next edge.
    assert_capture_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> !capture_o);

    // R6: the counter never runs past the last edge of the window.
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LAST));

endmodule

// File: rtl/strap_mode_latch.sv
// Module strap_mode_latch
// Purpose : latches the test-mode and clock-select straps around reset
//           release and holds the resulting modes until the next reset.
// Assumes : rst_n is synchronous to clk; straps are active low, pulled up
//           during reset; clock-select straps are stable at release.
module strap_mode_latch #(
    parameter int SYNC_STAGES    = 2,
    parameter int CAPTURE_WINDOW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] test_strap_n,
    input  logic [1:0] ck_strap_n,
    output logic       test_hiz,
    output logic [1:0] clk_mode,
    output logic       strap_pull_en
);
    import msl_pkg::*;

    localparam int NSTRAP = 4;

    logic [NSTRAP-1:0] strap_s;
    logic              release_w;
    logic              capture_w;
    logic              hiz_q;
    ckmode_e           mode_q;

    msl_sync #(.WIDTH(NSTRAP), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   ({ck_strap_n, test_strap_n}),
        .q   (strap_s)
    );

    msl_window #(.WINDOW(CAPTURE_WINDOW)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_o (release_w),
        .capture_o (capture_w)
    );

    // Mode registers: defaults in reset, single capture after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q  <= 1'b0;
            mode_q <= CKM_X4;
        end else begin
            if (release_w) hiz_q  <= ~|strap_s[1:0];
            if (capture_w) mode_q <= decode_ck(strap_s[3:2]);
        end
    end

    assign test_hiz      = hiz_q;
    assign clk_mode      = mode_q;
    assign strap_pull_en = ~rst_n;

    // R1: reset forces normal mode and the x4 default.
    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> (!test_hiz && clk_mode == 2'b10));

    // R4: test mode only moves on the release edge.
    assert_hiz_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !release_w |=> $stable(test_hiz));

    // R9: the clock code only moves on the capture edge.
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_w |=> $stable(clk_mode));

    // R9: the unused code never appears.
    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode != 2'b11);

endmodule

// File: tb/sim_strap_mode_latch.sv
module sim_strap_mode_latch;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] test_strap_n = 2'b11;
    logic [1:0] ck_strap_n = 2'b11;
    logic       test_hiz;
    logic [1:0] clk_mode;
    logic       strap_pull_en;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic       hiz;
        logic [1:0] mode;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    logic req = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_mode_latch u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_strap_n  (test_strap_n),
        .ck_strap_n    (ck_strap_n),
        .test_hiz      (test_hiz),
        .clk_mode      (clk_mode),
        .strap_pull_en (strap_pull_en)
    );

    // Expected multiplier code from the requirement table (R5).
    function automatic logic [1:0] exp_mode(input logic [1:0] sel_n);
        if (!sel_n[1])      return 2'b00;
        else if (!sel_n[0]) return 2'b01;
        else                return 2'b10;
    endfunction

    // Driver side: queue an expected result; the monitor checks it at the next falling edge.
    task automatic expect_now(input logic h, input logic [1:0] m, input string tag);
        exp_t e;
        e.hiz = h; e.mode = m; e.tag = tag;
        sbq.push_back(e);
        req = 1'b1;
        wait (req == 1'b0);
    endtask

    task automatic check_pull(input logic exp, input string tag);
        n_run++;
        if (strap_pull_en !== exp) begin
            n_fail++;
            $display("FAIL %s strap_pull_en actual=%b expected=%b", tag, strap_pull_en, exp);
        end
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (req && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_run++;
            if (test_hiz !== e.hiz || clk_mode !== e.mode) begin
                n_fail++;
                $display("FAIL %s actual hiz=%b mode=%b expected hiz=%b mode=%b",
                         e.tag, test_hiz, clk_mode, e.hiz, e.mode);
            end
            req <= 1'b0;
        end
    end

    // Full reset cycle for one strap combination.
    task automatic run_case(input logic [1:0] ts, input logic [1:0] cs);
        logic eh;
        logic [1:0] em;
        eh = (ts == 2'b00);
        em = exp_mode(cs);
        rst_n = 1'b0;
        test_strap_n = ts;
        ck_strap_n = cs;
        repeat (4) @(posedge clk);
        #1;
        expect_now(1'b0, 2'b10, "R1 reset defaults");
        check_pull(1'b1, "R2 pull during reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        expect_now(eh, 2'b10, "R3 release capture / R6 before window");
        check_pull(1'b0, "R2 pull after release");
        test_strap_n = ~ts;
        ck_strap_n = ~cs;
        @(posedge clk); #1;
        expect_now(eh, 2'b10, "R6 default held mid window");
        @(posedge clk); #1;
        expect_now(eh, em, "R5 R6 clock mode captured");
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            test_strap_n = test_strap_n + 2'd1;
            ck_strap_n = ck_strap_n + 2'd3;
        end
        expect_now(eh, em, "R4 R7 R9 hold after release");
    endtask

    // Late strap change: taken after the synchronizer's last sample before release.
    task automatic run_late_change;
        rst_n = 1'b0;
        test_strap_n = 2'b00;
        ck_strap_n = 2'b11;
        repeat (5) @(posedge clk);
        #1;
        test_strap_n = 2'b11;
        ck_strap_n = 2'b01;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        expect_now(1'b1, 2'b10, "R8 test strap from two edges before release");
        repeat (2) @(posedge clk);
        #1;
        expect_now(1'b1, 2'b00, "R6 clock strap from release edge");
    endtask

    initial begin
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c < 4; c++) begin
                run_case(2'(t), 2'(c));
            end
        end
        run_late_change();
        run_case(2'b11, 2'b11);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished == 1'b1);
            begin
                #(CLK_PERIOD * 100000);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule